// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retire and Head-Triggered Flush

This block tracks every micro-op that leaves dispatch, in program order, in a circular table. The dispatch stage places each micro-op into the next free slot and receives that slot's index, which travels with the micro-op. Execution units later report completion by index. The buffer lets completed micro-ops leave strictly from the oldest end, one per cycle. Architectural effects happen only at that point: the physical register that the micro-op's destination replaced goes back to the free list, and a store is allowed to write memory.

The oldest entry also controls two side effects. A completed store at the head asks the load/store unit to commit it and retires only in the cycle the commit is acknowledged. An uncompleted memory-mapped I/O access at the head is told it may now execute. Branch mispredictions are not repaired early. A branch reported as mispredicted waits until it becomes the oldest entry. When it retires, the buffer drives a redirect with the corrected PC together with a flush, and drops every younger entry on the same clock edge.

The slot count is a parameter and must be a power of two. Head and tail pointers carry one extra wrap bit, so a full table can be told apart from an empty one.

Top module: `reorder_buf`

## Requirements
- R1: After synchronous reset the buffer is empty. `alloc_ready` is 1 and `alloc_idx` is 0. `ret_valid`, `free_valid`, `flush_valid`, `store_commit_req` and `mmio_at_head` are all 0.
- R2: An accepted allocation (`alloc_valid` and `alloc_ready`) takes the slot shown on `alloc_idx`, and `alloc_idx` then steps by one modulo DEPTH. `alloc_ready` is 0 exactly when DEPTH entries are held. An allocation offered while `alloc_ready` is 0 changes nothing.
- R3: At most one entry retires per clock. Only the oldest entry can retire, and only after it has been completed, so a younger completed entry waits for every older one. `ret_valid`, `ret_arch_rd` and `ret_new_preg` present the retired entry in the cycle after the retire decision.
- R4: When an entry that writes a destination retires, `free_valid` is 1 in the same cycle as `ret_valid`, and `free_preg` carries the superseded physical tag given at allocation. When the entry has no destination, `free_valid` stays 0.
- R5: `store_commit_req` is 1 while the oldest entry is a completed store. That entry retires in a cycle only if `store_commit_ack` is 1 in that cycle. `store_commit_ack` has no effect in any other cycle.
- R6: `mmio_at_head` is 1 exactly when the oldest entry is an I/O access that has not yet completed.
- R7: When a completed entry whose writeback set `wb_mispredict` retires, `flush_valid` is 1 and `redirect_pc` equals that writeback's `wb_target`, both in the cycle after retire. On the same edge all younger entries are dropped, so the buffer is empty and `alloc_idx` points at the slot just after the branch.
- R8: An allocation offered in the same cycle as a mispredicted retire is discarded.
- R9: A writeback naming a slot that holds no entry has no effect. A later micro-op allocated into that slot still waits for its own completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid | input | 1 | Dispatch offers a micro-op |
| alloc_ready | output | 1 | A free slot exists |
| alloc_idx | output | IDX_W | Slot the next allocation takes |
| alloc_arch_rd | input | AREG_W | Architectural destination register |
| alloc_has_dest | input | 1 | Micro-op writes a destination |
| alloc_new_preg | input | PREG_W | Newly mapped physical tag |
| alloc_old_preg | input | PREG_W | Superseded physical tag |
| alloc_is_store | input | 1 | Micro-op is a store |
| alloc_is_mmio | input | 1 | Micro-op is a memory-mapped I/O access |
| wb_valid | input | 1 | Completion report |
| wb_idx | input | IDX_W | Slot being completed |
| wb_mispredict | input | 1 | Completed branch was mispredicted |
| wb_target | input | PC_W | Correct PC for a mispredicted branch |
| store_commit_req | output | 1 | Head store may be written to memory |
| store_commit_ack | input | 1 | Load/store unit accepts the head store |
| mmio_at_head | output | 1 | Head I/O access may execute |
| ret_valid | output | 1 | An entry retired (registered) |
| ret_arch_rd | output | AREG_W | Retired architectural destination |
| ret_new_preg | output | PREG_W | Retired physical tag |
| free_valid | output | 1 | Return a tag to the free list |
| free_preg | output | PREG_W | Tag being returned |
| flush_valid | output | 1 | Flush all younger state |
| redirect_pc | output | PC_W | Fetch restart address |

## Verification
On every cycle the assertions check the following: occupancy never exceeds DEPTH, the tail never moves while the buffer is full, a flush always leaves the buffer empty, a retire is always preceded by a completed head, a store still waiting for acknowledgment never retires, and a free or flush never appears without a retire. Some behaviours are only shown by the bench's scenarios, because each needs a specific history compared against a reference queue model. These are: younger entries completing first and still retiring in order, the exact superseded tag returned, the redirect address, the wrap of the slot index, an allocation that collides with a flush, and a completion sent to an empty slot.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef struct packed {
    logic has_dest;
    logic is_store;
    logic is_mmio;
  } rob_kind_t;

  localparam int unsigned KIND_W = 3;

  function automatic int unsigned rob_payload_w(int unsigned areg_w, int unsigned preg_w);
    return KIND_W + areg_w + 2 * preg_w;
  endfunction

endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             alloc_fire,
  input  logic             retire_fire,
  input  logic             flush,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = IDX_W + 1;

  logic [PTR_W-1:0] head_q, tail_q, head_nx, occ;

  assign head_nx = head_q + PTR_W'(retire_fire);

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_nx;
      if (flush)
        tail_q <= head_nx;
      else if (alloc_fire)
        tail_q <= tail_q + PTR_W'(1);
    end
  end

  assign head_idx = head_q[IDX_W-1:0];
  assign tail_idx = tail_q[IDX_W-1:0];
  assign empty    = (head_q == tail_q);
  assign full     = (head_idx == tail_idx) && (head_q[IDX_W] != tail_q[IDX_W]);
  assign occ      = tail_q - head_q;

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (rst)
    occ <= PTR_W'(DEPTH));

  p_full_holds_tail_r2: assert property (@(posedge clk) disable iff (rst)
    (full && !flush) |=> $stable(tail_q));

  p_flush_empties_r7: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);

endmodule

// File: rtl/rob_ram.sv
module rob_ram #(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [IDX_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we)
      mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/rob_status.sv
module rob_status #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic             alloc_fire,
  input  logic [IDX_W-1:0] alloc_idx,
  input  logic             wb_valid,
  input  logic [IDX_W-1:0] wb_idx,
  input  logic             wb_mispredict,
  input  logic             retire_fire,
  input  logic [IDX_W-1:0] head_idx,
  output logic             wb_hit,
  output logic             head_valid,
  output logic             head_done,
  output logic             head_mispred
);
  logic [DEPTH-1:0] valid_q, done_q, mis_q;
  logic [DEPTH-1:0] valid_d, done_d, mis_d;

  assign wb_hit = wb_valid && valid_q[wb_idx];

  always_comb begin
    valid_d = valid_q;
    done_d  = done_q;
    mis_d   = mis_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (alloc_fire && alloc_idx == IDX_W'(i)) begin
        valid_d[i] = 1'b1;
        done_d[i]  = 1'b0;
        mis_d[i]   = 1'b0;
      end else if (wb_hit && wb_idx == IDX_W'(i)) begin
        done_d[i] = 1'b1;
        mis_d[i]  = wb_mispredict;
      end
      if (retire_fire && head_idx == IDX_W'(i))
        valid_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      valid_q <= '0;
      done_q  <= '0;
      mis_q   <= '0;
    end else begin
      valid_q <= valid_d;
      done_q  <= done_d;
      mis_q   <= mis_d;
    end
  end

  assign head_valid   = valid_q[head_idx];
  assign head_done    = done_q[head_idx];
  assign head_mispred = mis_q[head_idx];

endmodule

// File: rtl/reorder_buf.sv
module reorder_buf
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int AREG_W = 5,
  parameter int PREG_W = 6,
  parameter int PC_W   = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc_valid,
  output logic              alloc_ready,
  output logic [IDX_W-1:0]  alloc_idx,
  input  logic [AREG_W-1:0] alloc_arch_rd,
  input  logic              alloc_has_dest,
  input  logic [PREG_W-1:0] alloc_new_preg,
  input  logic [PREG_W-1:0] alloc_old_preg,
  input  logic              alloc_is_store,
  input  logic              alloc_is_mmio,
  input  logic              wb_valid,
  input  logic [IDX_W-1:0]  wb_idx,
  input  logic              wb_mispredict,
  input  logic [PC_W-1:0]   wb_target,
  output logic              store_commit_req,
  input  logic              store_commit_ack,
  output logic              mmio_at_head,
  output logic              ret_valid,
  output logic [AREG_W-1:0] ret_arch_rd,
  output logic [PREG_W-1:0] ret_new_preg,
  output logic              free_valid,
  output logic [PREG_W-1:0] free_preg,
  output logic              flush_valid,
  output logic [PC_W-1:0]   redirect_pc
);
  localparam int PAY_W = int'(rob_payload_w(AREG_W, PREG_W));

  logic [IDX_W-1:0]  head_idx, tail_idx;
  logic              full, empty;
  logic              alloc_fire, retire_fire, flush_now;
  logic              wb_hit, head_valid, head_done, head_mispred, head_can;
  logic [PAY_W-1:0]  alloc_payload, head_payload;
  logic [PC_W-1:0]   head_target;
  rob_kind_t         alloc_kind, head_kind;
  logic [AREG_W-1:0] head_rd;
  logic [PREG_W-1:0] head_new, head_old;

  assign alloc_kind    = '{has_dest: alloc_has_dest, is_store: alloc_is_store, is_mmio: alloc_is_mmio};
  assign alloc_payload = {alloc_kind, alloc_arch_rd, alloc_new_preg, alloc_old_preg};
  assign {head_kind, head_rd, head_new, head_old} = head_payload;

  assign head_can    = head_valid && head_done;
  assign retire_fire = head_can && (!head_kind.is_store || store_commit_ack);
  assign flush_now   = retire_fire && head_mispred;
  assign alloc_ready = !full;
  assign alloc_fire  = alloc_valid && !full && !flush_now;
  assign alloc_idx   = tail_idx;

  assign store_commit_req = head_can && head_kind.is_store;
  assign mmio_at_head     = head_valid && !head_done && head_kind.is_mmio;

  rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptrs (
    .clk        (clk),
    .rst        (rst),
    .alloc_fire (alloc_fire),
    .retire_fire(retire_fire),
    .flush      (flush_now),
    .head_idx   (head_idx),
    .tail_idx   (tail_idx),
    .full       (full),
    .empty      (empty)
  );

  rob_status #(.DEPTH(DEPTH)) u_status (
    .clk          (clk),
    .rst          (rst),
    .flush        (flush_now),
    .alloc_fire   (alloc_fire),
    .alloc_idx    (tail_idx),
    .wb_valid     (wb_valid),
    .wb_idx       (wb_idx),
    .wb_mispredict(wb_mispredict),
    .retire_fire  (retire_fire),
    .head_idx     (head_idx),
    .wb_hit       (wb_hit),
    .head_valid   (head_valid),
    .head_done    (head_done),
    .head_mispred (head_mispred)
  );

  rob_ram #(.DEPTH(DEPTH), .DATA_W(PAY_W)) u_payload (
    .clk  (clk),
    .we   (alloc_fire),
    .waddr(tail_idx),
    .wdata(alloc_payload),
    .raddr(head_idx),
    .rdata(head_payload)
  );

  rob_ram #(.DEPTH(DEPTH), .DATA_W(PC_W)) u_target (
    .clk  (clk),
    .we   (wb_hit),
    .waddr(wb_idx),
    .wdata(wb_target),
    .raddr(head_idx),
    .rdata(head_target)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ret_valid    <= 1'b0;
      ret_arch_rd  <= '0;
      ret_new_preg <= '0;
      free_valid   <= 1'b0;
      free_preg    <= '0;
      flush_valid  <= 1'b0;
      redirect_pc  <= '0;
    end else begin
      ret_valid   <= retire_fire;
      free_valid  <= retire_fire && head_kind.has_dest;
      flush_valid <= flush_now;
      if (retire_fire) begin
        ret_arch_rd  <= head_rd;
        ret_new_preg <= head_new;
        free_preg    <= head_old;
        redirect_pc  <= head_target;
      end
    end
  end

  p_retire_after_done_r3: assert property (@(posedge clk) disable iff (rst)
    ret_valid |-> $past(head_valid && head_done && !empty));

  p_store_waits_ack_r5: assert property (@(posedge clk) disable iff (rst)
    (store_commit_req && !store_commit_ack) |=> !ret_valid);

  p_free_with_retire_r4: assert property (@(posedge clk) disable iff (rst)
    free_valid |-> ret_valid);

  p_mmio_not_store_r6: assert property (@(posedge clk) disable iff (rst)
    mmio_at_head |-> !store_commit_req);

  p_flush_with_retire_r7: assert property (@(posedge clk) disable iff (rst)
    flush_valid |-> ret_valid);

endmodule

// File: tb/test_reorder_buf.sv
module test_reorder_buf;
  localparam int DEPTH = 8;
  localparam int AW = 5;
  localparam int PW = 6;
  localparam int CW = 32;
  localparam int IW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst;
  always #4 clk = ~clk;

  logic          alloc_valid, alloc_ready, alloc_has_dest, alloc_is_store, alloc_is_mmio;
  logic [IW-1:0] alloc_idx, wb_idx;
  logic [AW-1:0] alloc_arch_rd, ret_arch_rd;
  logic [PW-1:0] alloc_new_preg, alloc_old_preg, ret_new_preg, free_preg;
  logic          wb_valid, wb_mispredict, store_commit_req, store_commit_ack, mmio_at_head;
  logic          ret_valid, free_valid, flush_valid;
  logic [CW-1:0] wb_target, redirect_pc;

  reorder_buf #(.DEPTH(DEPTH), .AREG_W(AW), .PREG_W(PW), .PC_W(CW)) i_reorder_buf (
    .clk(clk), .rst(rst),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
    .alloc_arch_rd(alloc_arch_rd), .alloc_has_dest(alloc_has_dest),
    .alloc_new_preg(alloc_new_preg), .alloc_old_preg(alloc_old_preg),
    .alloc_is_store(alloc_is_store), .alloc_is_mmio(alloc_is_mmio),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_mispredict(wb_mispredict), .wb_target(wb_target),
    .store_commit_req(store_commit_req), .store_commit_ack(store_commit_ack),
    .mmio_at_head(mmio_at_head),
    .ret_valid(ret_valid), .ret_arch_rd(ret_arch_rd), .ret_new_preg(ret_new_preg),
    .free_valid(free_valid), .free_preg(free_preg),
    .flush_valid(flush_valid), .redirect_pc(redirect_pc)
  );

  int n_chk = 0;
  int n_fail = 0;

  // reference model: occupancy window [m_head, m_head+m_cnt) over slot arrays
  int        m_rd[DEPTH], m_nw[DEPTH], m_old[DEPTH];
  bit        m_hd[DEPTH], m_st[DEPTH], m_mm[DEPTH], m_done[DEPTH], m_mis[DEPTH];
  bit [31:0] m_tgt[DEPTH];
  int        m_head = 0;
  int        m_cnt = 0;
  bit        e_rv, e_fv, e_fl;
  int        e_rd, e_nw, e_fp;
  bit [31:0] e_pc;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(int rd, int nw, int old, bit hd, bit st, bit mm);
    alloc_valid = 1'b1; alloc_arch_rd = AW'(rd); alloc_new_preg = PW'(nw);
    alloc_old_preg = PW'(old); alloc_has_dest = hd; alloc_is_store = st; alloc_is_mmio = mm;
  endtask

  task automatic wb(int idx, bit mis, bit [31:0] tgt);
    wb_valid = 1'b1; wb_idx = IW'(idx); wb_mispredict = mis; wb_target = tgt;
  endtask

  task automatic tick();
    bit ready, can, sreq, mgo, ret, hit;
    int hi, tidx, off;
    #1;
    hi   = m_head;
    tidx = (m_head + m_cnt) % DEPTH;
    ready = (m_cnt < DEPTH);
    can  = (m_cnt > 0) && m_done[hi];
    sreq = can && m_st[hi];
    mgo  = (m_cnt > 0) && m_mm[hi] && !m_done[hi];
    check("R2 alloc_ready", alloc_ready, ready);
    check("R2 alloc_idx", alloc_idx, tidx);
    check("R5 store_commit_req", store_commit_req, sreq);
    check("R6 mmio_at_head", mmio_at_head, mgo);
    ret  = can && (!m_st[hi] || store_commit_ack);
    e_rv = ret; e_fv = ret && m_hd[hi]; e_fl = ret && m_mis[hi];
    if (ret) begin e_rd = m_rd[hi]; e_nw = m_nw[hi]; e_fp = m_old[hi]; e_pc = m_tgt[hi]; end
    off = (int'(wb_idx) - hi + DEPTH) % DEPTH;
    hit = wb_valid && (off < m_cnt);
    if (hit) begin
      m_done[wb_idx] = 1'b1; m_mis[wb_idx] = wb_mispredict; m_tgt[wb_idx] = wb_target;
    end
    if (ret) begin m_head = (m_head + 1) % DEPTH; m_cnt--; end
    if (e_fl) m_cnt = 0;
    else if (alloc_valid && ready) begin
      m_rd[tidx] = alloc_arch_rd; m_nw[tidx] = alloc_new_preg; m_old[tidx] = alloc_old_preg;
      m_hd[tidx] = alloc_has_dest; m_st[tidx] = alloc_is_store; m_mm[tidx] = alloc_is_mmio;
      m_done[tidx] = 1'b0; m_mis[tidx] = 1'b0;
      m_cnt++;
    end
    @(posedge clk);
    @(negedge clk);
    check("R3 ret_valid", ret_valid, e_rv);
    if (e_rv) begin
      check("R3 ret_arch_rd", ret_arch_rd, e_rd);
      check("R3 ret_new_preg", ret_new_preg, e_nw);
    end
    check("R4 free_valid", free_valid, e_fv);
    if (e_fv) check("R4 free_preg", free_preg, e_fp);
    check("R7 flush_valid", flush_valid, e_fl);
    if (e_fl) check("R7 redirect_pc", redirect_pc, e_pc);
    alloc_valid = 1'b0; wb_valid = 1'b0; wb_mispredict = 1'b0; store_commit_ack = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int s[12];
    int b;
    rst = 1'b1;
    alloc_valid = 1'b0; alloc_arch_rd = '0; alloc_new_preg = '0; alloc_old_preg = '0;
    alloc_has_dest = 1'b0; alloc_is_store = 1'b0; alloc_is_mmio = 1'b0;
    wb_valid = 1'b0; wb_idx = '0; wb_mispredict = 1'b0; wb_target = '0;
    store_commit_ack = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    // R1 reset state
    check("R1 alloc_ready", alloc_ready, 1);
    check("R1 alloc_idx", alloc_idx, 0);
    check("R1 ret_valid", ret_valid, 0);
    check("R1 free_valid", free_valid, 0);
    check("R1 flush_valid", flush_valid, 0);
    check("R1 store_commit_req", store_commit_req, 0);
    check("R1 mmio_at_head", mmio_at_head, 0);

    // R3/R4: out-of-order completion, in-order retire, one op without destination
    for (int k = 0; k < 4; k++) begin
      s[k] = alloc_idx;
      put(k + 1, 10 + k, 20 + k, k != 2, 1'b0, 1'b0);
      tick();
    end
    wb(s[3], 1'b0, 0); tick();
    wb(s[2], 1'b0, 0); tick();
    wb(s[0], 1'b0, 0); tick();
    wb(s[1], 1'b0, 0); tick();
    idle(4);

    // R2: fill to DEPTH, offer while full, wrap, drain
    for (int k = 0; k < DEPTH; k++) begin
      s[k] = alloc_idx;
      put(k, 30 + k, 40 + k, 1'b1, 1'b0, 1'b0);
      tick();
    end
    put(31, 63, 62, 1'b1, 1'b0, 1'b0); tick();
    check("R2 full holds alloc_ready low", alloc_ready, 0);
    for (int k = DEPTH - 1; k >= 0; k--) begin
      wb(s[k], 1'b0, 0); tick();
    end
    idle(DEPTH + 2);

    // R5: store waits for acknowledgment
    s[0] = alloc_idx;
    put(0, 1, 2, 1'b0, 1'b1, 1'b0); tick();
    wb(s[0], 1'b0, 0); tick();
    idle(3);
    check("R5 store held without ack", ret_valid, 0);
    store_commit_ack = 1'b1; tick();
    idle(2);

    // R6: I/O access signalled only at the head
    s[0] = alloc_idx; put(5, 7, 8, 1'b1, 1'b0, 1'b0); tick();
    s[1] = alloc_idx; put(6, 9, 3, 1'b1, 1'b0, 1'b1); tick();
    idle(2);
    wb(s[0], 1'b0, 0); tick();
    idle(2);
    wb(s[1], 1'b0, 0); tick();
    idle(2);

    // R7/R8: mispredict drains to head, flushes younger, colliding allocation discarded
    b = alloc_idx;
    put(1, 11, 12, 1'b1, 1'b0, 1'b0); tick();
    for (int k = 0; k < 3; k++) begin
      s[k] = alloc_idx; put(2 + k, 13 + k, 16 + k, 1'b1, 1'b0, 1'b0); tick();
    end
    for (int k = 0; k < 3; k++) begin wb(s[k], 1'b0, 0); tick(); end
    wb(b, 1'b1, 32'h1234_5678); tick();
    put(9, 50, 51, 1'b1, 1'b0, 1'b0); tick();
    check("R7 flush raised", flush_valid, 1);
    check("R8 alloc_idx after flush", alloc_idx, (b + 1) % DEPTH);
    idle(2);
    check("R8 discarded alloc never retires", ret_valid, 0);
    s[0] = alloc_idx; put(3, 4, 5, 1'b1, 1'b0, 1'b0); tick();
    wb(s[0], 1'b0, 0); tick();
    idle(2);

    // R9: completion to an unoccupied slot is ignored
    s[0] = alloc_idx;
    wb(s[0], 1'b1, 32'hdead_beef); tick();
    put(7, 21, 22, 1'b1, 1'b0, 1'b0); tick();
    idle(3);
    check("R9 stale completion ignored", ret_valid, 0);
    wb(s[0], 1'b0, 0); tick();
    idle(2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule